// File: doc/BRIEF.md
# Capacitance Conversion Stage Sequencer

This block schedules the conversions of a capacitance-to-digital front end. A sequence walks through conversion stages in ascending order, beginning at stage 0 and ending at a programmed last stage. At most twelve stages are run. For each stage the block drives a registered input-switch code for every sensor pin to the converter. It marks each stage with a start pulse and marks the completed sequence with an end pulse and an interrupt level. The analog converter and its filter are not part of the block. An internal tick counter stands in for them, and the stage length follows the chosen oversampling ratio.

A two-bit power control input selects the operating mode. In full power mode, sequences run back-to-back. In low power mode, the block waits a long programmable delay after each sequence. While any sensor reports activity, it switches to a fixed 36 ms start-to-start cadence. Shutdown stops the schedule at the next stage boundary.

All times are counted in ticks of `TICK_US` microseconds. Each tick lasts `CYCLES_PER_TICK` clock cycles, so a bench can shrink milliseconds to a few cycles.

Top module: `capsense_seq_top`

## Requirements
- R1: After reset, the stage index is 0, there are no start or end pulses, the interrupt is low and every pin code is 00. With power code 00 applied, a stage 0 start pulse appears on the first clock edge after reset is released.
- R2: A sequence starts stages 0, 1, 2 and so on, one after another, up to the latched last-stage value. A value above 11 is treated as 11, so a sequence has min(last,11)+1 stages.
- R3: The stage length depends on the oversampling code. Code 00 gives 3.072 ms, code 01 gives 1.536 ms, and codes 10 and 11 give 0.768 ms. With a 32 us tick, these are 96, 48 and 24 ticks. Each stage start pulse is one cycle wide.
- R4: In full power mode (code 00), the next stage 0 starts in the same cycle as the end pulse. The start-to-start period is (stages × stage length).
- R5: In low power mode (code 10) with no sensor active at the end of a sequence, the next stage 0 starts exactly the wake delay after the end pulse. Wake code 00 gives 200 ms, 01 gives 400 ms, 10 gives 600 ms and 11 gives 800 ms.
- R6: In low power mode with a sensor active at the end of a sequence, sequences start 36 ms apart. If a sequence lasts longer than 36 ms, the next one starts back-to-back.
- R7: Power codes 01 and 11 are both shutdown. The stage in progress keeps its index and pin codes until it ends. After that there are no start or end pulses, the index is 0 and every pin code is 00.
- R8: The pin codes of stage s sit at bits [s*2P +: 2P] of the configuration input, where P is the number of pins. Pin p uses bits [2p+1:2p] of that row. Code 00 is floating, 01 is the negative input, 10 is the positive input and 11 is bias. The row is output unchanged from the stage start. All codes are 00 between sequences.
- R9: The last-stage and oversampling inputs are captured when a sequence starts. Changing them during a sequence only affects the next sequence.
- R10: The interrupt rises together with the end pulse. It falls when stage 0 of the following sequence ends, or when shutdown takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_mode_i | input | 2 | 00 full power, 10 low power, 01/11 shutdown |
| decim_i | input | 2 | Oversampling code (stage length) |
| last_stage_i | input | STAGE_W | Index of the final stage of a sequence |
| wake_dly_i | input | 2 | Low power delay code |
| any_active_i | input | 1 | Some sensor is currently active |
| mux_cfg_i | input | NUM_STAGES*NUM_PINS*2 | Per-stage, per-pin switch codes |
| stage_idx_o | output | STAGE_W | Stage currently converting |
| stage_start_o | output | 1 | One-cycle pulse at each stage start |
| seq_end_o | output | 1 | One-cycle pulse when a sequence completes |
| seq_irq_o | output | 1 | Sequence-complete interrupt level |
| mux_sel_o | output | NUM_PINS*2 | Switch codes for the current stage |

## Verification
Several kinds of internal fault show up on the ports within one stage:
- If the latched last stage or oversampling code is wrong, the start-to-start period changes on the very next sequence.
- If a stage counter loads the wrong value, the next stage start pulse moves within one stage length.
- If the index register is wrong, the pin codes no longer match the configuration row of the reported index.

Two kinds of wait-state fault take longer to appear:
- If the block picks the wrong wait state or delay, the next stage 0 start is late or early. This shows up only after a full delay of up to 800 ms in ticks.
- If the shutdown handling is wrong, a stray start pulse appears at the first stage boundary after the shutdown code is applied.

// File: rtl/capsense_seq_pkg.sv
package capsense_seq_pkg;

  typedef enum logic [1:0] {
    ST_OFF       = 2'd0,
    ST_CONV      = 2'd1,
    ST_WAIT_SLOW = 2'd2,
    ST_WAIT_FAST = 2'd3
  } seq_state_e;

  typedef enum logic [1:0] {
    PIN_FLOAT = 2'b00,
    PIN_NEG   = 2'b01,
    PIN_POS   = 2'b10,
    PIN_BIAS  = 2'b11
  } pin_code_e;

  localparam logic [1:0] MODE_FULL = 2'b00;
  localparam logic [1:0] MODE_LOW  = 2'b10;

  function automatic logic mode_is_off(input logic [1:0] m);
    return m[0];
  endfunction

endpackage

// File: rtl/capsense_tick.sv
module capsense_tick #(
  parameter int unsigned CYCLES_PER_TICK = 4000
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  localparam int unsigned CW = (CYCLES_PER_TICK > 1) ? $clog2(CYCLES_PER_TICK) : 1;
  localparam logic [CW-1:0] WRAP = CW'(CYCLES_PER_TICK - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else begin
      tick_o <= (cnt_q == WRAP);
      if (cnt_q == WRAP) cnt_q <= '0;
      else               cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/capsense_down_ctr.sv
module capsense_down_ctr #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         tick_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                          cnt_q <= '0;
    else if (load_i)                  cnt_q <= load_val_i;
    else if (tick_i && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/capsense_mux_out.sv
module capsense_mux_out #(
  parameter int unsigned NUM_STAGES = 12,
  parameter int unsigned NUM_PINS   = 13,
  parameter int unsigned STAGE_W    = 4
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [NUM_STAGES*NUM_PINS*2-1:0] cfg_i,
  input  logic                           load_i,
  input  logic [STAGE_W-1:0]             idx_i,
  input  logic                           clear_i,
  output logic [NUM_PINS*2-1:0]          sel_o
);
  localparam int unsigned ROW_W = NUM_PINS * 2;

  logic [ROW_W-1:0] rows [NUM_STAGES];

  for (genvar s = 0; s < NUM_STAGES; s++) begin : g_row
    assign rows[s] = cfg_i[s*ROW_W +: ROW_W];
  end

  always_ff @(posedge clk) begin
    if (rst || clear_i) sel_o <= '0;
    else if (load_i)    sel_o <= rows[idx_i];
  end
endmodule

// File: rtl/capsense_seq_ctrl.sv
module capsense_seq_ctrl
  import capsense_seq_pkg::*;
#(
  parameter int unsigned NUM_STAGES = 12,
  parameter int unsigned STAGE_W    = 4,
  parameter int unsigned SCW        = 7,
  parameter int unsigned PCW        = 11,
  parameter int unsigned DCW        = 15,
  parameter int unsigned STG_T0     = 96,
  parameter int unsigned STG_T1     = 48,
  parameter int unsigned STG_T2     = 24,
  parameter int unsigned FAST_T     = 1125,
  parameter int unsigned DLY_STEP   = 6250
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick_i,
  input  logic [1:0]         pwr_mode_i,
  input  logic [1:0]         decim_i,
  input  logic [STAGE_W-1:0] last_stage_i,
  input  logic [1:0]         wake_dly_i,
  input  logic               any_active_i,
  input  logic               stg_zero_i,
  input  logic               per_zero_i,
  input  logic               dly_zero_i,
  output logic               stg_load_o,
  output logic [SCW-1:0]     stg_val_o,
  output logic               per_load_o,
  output logic [PCW-1:0]     per_val_o,
  output logic               dly_load_o,
  output logic [DCW-1:0]     dly_val_o,
  output logic               mux_load_o,
  output logic               mux_clear_o,
  output logic [STAGE_W-1:0] mux_idx_o,
  output logic [STAGE_W-1:0] stage_idx_o,
  output logic               stage_start_o,
  output logic               seq_end_o,
  output logic               seq_irq_o
);
  localparam logic [STAGE_W-1:0] MAX_IDX = STAGE_W'(NUM_STAGES - 1);

  seq_state_e        st_q;
  logic [STAGE_W-1:0] last_q;
  logic [1:0]        dec_q;

  logic shut, low, stage_end, is_last;
  logic start_seq, next_stage, go_off, go_slow, go_fast, seq_done;
  logic [STAGE_W-1:0] last_clamped;

  function automatic logic [SCW-1:0] stage_len(input logic [1:0] d);
    case (d)
      2'b00:   return SCW'(STG_T0 - 1);
      2'b01:   return SCW'(STG_T1 - 1);
      default: return SCW'(STG_T2 - 1);
    endcase
  endfunction

  function automatic logic [DCW-1:0] wake_len(input logic [1:0] w);
    case (w)
      2'b00:   return DCW'(1 * DLY_STEP - 1);
      2'b01:   return DCW'(2 * DLY_STEP - 1);
      2'b10:   return DCW'(3 * DLY_STEP - 1);
      default: return DCW'(4 * DLY_STEP - 1);
    endcase
  endfunction

  always_comb begin
    shut         = mode_is_off(pwr_mode_i);
    low          = (pwr_mode_i == MODE_LOW);
    stage_end    = (st_q == ST_CONV) && tick_i && stg_zero_i;
    is_last      = (stage_idx_o == last_q);
    last_clamped = (last_stage_i > MAX_IDX) ? MAX_IDX : last_stage_i;
    start_seq    = 1'b0;
    next_stage   = 1'b0;
    go_off       = 1'b0;
    go_slow      = 1'b0;
    go_fast      = 1'b0;
    unique case (st_q)
      ST_OFF: begin
        if (!shut) start_seq = 1'b1;
      end
      ST_CONV: begin
        if (stage_end) begin
          if (shut)                      go_off     = 1'b1;
          else if (!is_last)             next_stage = 1'b1;
          else if (!low)                 start_seq  = 1'b1;
          else if (!any_active_i)        go_slow    = 1'b1;
          else if (per_zero_i)           start_seq  = 1'b1;
          else                           go_fast    = 1'b1;
        end
      end
      ST_WAIT_SLOW: begin
        if (shut)                        go_off    = 1'b1;
        else if (!low)                   start_seq = 1'b1;
        else if (tick_i && dly_zero_i)   start_seq = 1'b1;
      end
      ST_WAIT_FAST: begin
        if (shut)                        go_off    = 1'b1;
        else if (!low)                   start_seq = 1'b1;
        else if (tick_i && per_zero_i)   start_seq = 1'b1;
      end
      default: go_off = 1'b1;
    endcase
    seq_done = stage_end && !shut && is_last;
  end

  assign stg_load_o  = start_seq || next_stage;
  assign stg_val_o   = start_seq ? stage_len(decim_i) : stage_len(dec_q);
  assign per_load_o  = start_seq;
  assign per_val_o   = PCW'(FAST_T - 1);
  assign dly_load_o  = go_slow;
  assign dly_val_o   = wake_len(wake_dly_i);
  assign mux_load_o  = start_seq || next_stage;
  assign mux_clear_o = go_off || go_slow || go_fast;
  assign mux_idx_o   = start_seq ? '0 : stage_idx_o + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q          <= ST_OFF;
      last_q        <= '0;
      dec_q         <= '0;
      stage_idx_o   <= '0;
      stage_start_o <= 1'b0;
      seq_end_o     <= 1'b0;
      seq_irq_o     <= 1'b0;
    end else begin
      stage_start_o <= start_seq || next_stage;
      seq_end_o     <= seq_done;
      if (start_seq) begin
        st_q        <= ST_CONV;
        stage_idx_o <= '0;
        last_q      <= last_clamped;
        dec_q       <= decim_i;
      end else if (next_stage) begin
        stage_idx_o <= stage_idx_o + 1'b1;
      end else if (go_off) begin
        st_q        <= ST_OFF;
        stage_idx_o <= '0;
      end else if (go_slow) begin
        st_q        <= ST_WAIT_SLOW;
        stage_idx_o <= '0;
      end else if (go_fast) begin
        st_q        <= ST_WAIT_FAST;
        stage_idx_o <= '0;
      end
      if (go_off)                               seq_irq_o <= 1'b0;
      else if (seq_done)                        seq_irq_o <= 1'b1;
      else if (stage_end && stage_idx_o == '0)  seq_irq_o <= 1'b0;
    end
  end
endmodule

// File: rtl/capsense_seq_top.sv
module capsense_seq_top #(
  parameter int unsigned NUM_STAGES      = 12,
  parameter int unsigned NUM_PINS        = 13,
  parameter int unsigned TICK_US         = 32,
  parameter int unsigned CYCLES_PER_TICK = 4000,
  parameter int unsigned STAGE_W         = $clog2(NUM_STAGES)
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [1:0]                       pwr_mode_i,
  input  logic [1:0]                       decim_i,
  input  logic [STAGE_W-1:0]               last_stage_i,
  input  logic [1:0]                       wake_dly_i,
  input  logic                             any_active_i,
  input  logic [NUM_STAGES*NUM_PINS*2-1:0] mux_cfg_i,
  output logic [STAGE_W-1:0]               stage_idx_o,
  output logic                             stage_start_o,
  output logic                             seq_end_o,
  output logic                             seq_irq_o,
  output logic [NUM_PINS*2-1:0]            mux_sel_o
);
  localparam int unsigned STG_T0   = 3072 / TICK_US;
  localparam int unsigned STG_T1   = 1536 / TICK_US;
  localparam int unsigned STG_T2   = 768 / TICK_US;
  localparam int unsigned FAST_T   = 36000 / TICK_US;
  localparam int unsigned DLY_STEP = 200000 / TICK_US;
  localparam int unsigned SCW      = $clog2(STG_T0 + 1);
  localparam int unsigned PCW      = $clog2(FAST_T + 1);
  localparam int unsigned DCW      = $clog2(4 * DLY_STEP + 1);

  logic tick;
  logic stg_load, per_load, dly_load;
  logic [SCW-1:0] stg_val;
  logic [PCW-1:0] per_val;
  logic [DCW-1:0] dly_val;
  logic stg_zero, per_zero, dly_zero;
  logic mux_load, mux_clear;
  logic [STAGE_W-1:0] mux_idx;

  capsense_tick #(.CYCLES_PER_TICK(CYCLES_PER_TICK)) u_tick (
    .clk(clk), .rst(rst), .tick_o(tick)
  );

  capsense_down_ctr #(.W(SCW)) u_stage_ctr (
    .clk(clk), .rst(rst), .load_i(stg_load), .load_val_i(stg_val),
    .tick_i(tick), .zero_o(stg_zero)
  );

  capsense_down_ctr #(.W(PCW)) u_period_ctr (
    .clk(clk), .rst(rst), .load_i(per_load), .load_val_i(per_val),
    .tick_i(tick), .zero_o(per_zero)
  );

  capsense_down_ctr #(.W(DCW)) u_wake_ctr (
    .clk(clk), .rst(rst), .load_i(dly_load), .load_val_i(dly_val),
    .tick_i(tick), .zero_o(dly_zero)
  );

  capsense_seq_ctrl #(
    .NUM_STAGES(NUM_STAGES), .STAGE_W(STAGE_W), .SCW(SCW), .PCW(PCW), .DCW(DCW),
    .STG_T0(STG_T0), .STG_T1(STG_T1), .STG_T2(STG_T2),
    .FAST_T(FAST_T), .DLY_STEP(DLY_STEP)
  ) u_ctrl (
    .clk(clk), .rst(rst), .tick_i(tick),
    .pwr_mode_i(pwr_mode_i), .decim_i(decim_i), .last_stage_i(last_stage_i),
    .wake_dly_i(wake_dly_i), .any_active_i(any_active_i),
    .stg_zero_i(stg_zero), .per_zero_i(per_zero), .dly_zero_i(dly_zero),
    .stg_load_o(stg_load), .stg_val_o(stg_val),
    .per_load_o(per_load), .per_val_o(per_val),
    .dly_load_o(dly_load), .dly_val_o(dly_val),
    .mux_load_o(mux_load), .mux_clear_o(mux_clear), .mux_idx_o(mux_idx),
    .stage_idx_o(stage_idx_o), .stage_start_o(stage_start_o),
    .seq_end_o(seq_end_o), .seq_irq_o(seq_irq_o)
  );

  capsense_mux_out #(
    .NUM_STAGES(NUM_STAGES), .NUM_PINS(NUM_PINS), .STAGE_W(STAGE_W)
  ) u_mux (
    .clk(clk), .rst(rst), .cfg_i(mux_cfg_i), .load_i(mux_load),
    .idx_i(mux_idx), .clear_i(mux_clear), .sel_o(mux_sel_o)
  );
endmodule

// File: rtl/capsense_seq_chk.sv
module capsense_seq_chk #(
  parameter int unsigned NUM_PINS = 13,
  parameter int unsigned STAGE_W  = 4
) (
  input logic                  clk,
  input logic                  rst,
  input logic [1:0]            pwr_mode_i,
  input logic [STAGE_W-1:0]    stage_idx_o,
  input logic                  stage_start_o,
  input logic                  seq_end_o,
  input logic                  seq_irq_o,
  input logic [NUM_PINS*2-1:0] mux_sel_o
);
  // R7: no stage may start while shutdown was requested on the prior edge
  assert_start_needs_power_R7: assert property (@(posedge clk) disable iff (rst)
    stage_start_o |-> !$past(pwr_mode_i[0]));

  // R2: stages within a sequence advance by exactly one
  assert_stage_step_R2: assert property (@(posedge clk) disable iff (rst)
    (stage_start_o && stage_idx_o != '0) |-> stage_idx_o == STAGE_W'($past(stage_idx_o) + 1'b1));

  // R10: the interrupt is high whenever a sequence completes
  assert_irq_with_end_R10: assert property (@(posedge clk) disable iff (rst)
    seq_end_o |-> seq_irq_o);

  // R4: full power restarts at stage 0 in the completion cycle
  assert_back_to_back_R4: assert property (@(posedge clk) disable iff (rst)
    (seq_end_o && $past(pwr_mode_i) == 2'b00) |-> (stage_start_o && stage_idx_o == '0));

  // R8: pins float while waiting after a sequence
  assert_float_in_wait_R8: assert property (@(posedge clk) disable iff (rst)
    (seq_end_o && !stage_start_o) |-> mux_sel_o == '0);

  // R3: stage start pulses last a single cycle
  assert_single_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    stage_start_o |=> !stage_start_o);
endmodule

bind capsense_seq_top capsense_seq_chk #(.NUM_PINS(NUM_PINS), .STAGE_W(STAGE_W)) u_chk (
  .clk(clk), .rst(rst), .pwr_mode_i(pwr_mode_i), .stage_idx_o(stage_idx_o),
  .stage_start_o(stage_start_o), .seq_end_o(seq_end_o), .seq_irq_o(seq_irq_o),
  .mux_sel_o(mux_sel_o)
);

// File: tb/tb_capsense_seq_top.sv
module tb_capsense_seq_top;
  localparam int NS = 12;
  localparam int NP = 13;
  localparam int SW = 4;
  localparam int ROW = NP * 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] pwr_mode = 2'b00;
  logic [1:0] decim = 2'b10;
  logic [SW-1:0] last_stage = 4'd2;
  logic [1:0] wake = 2'b00;
  logic any_active = 1'b0;
  logic [NS*NP*2-1:0] cfg;
  logic [SW-1:0] idx;
  logic st_pulse, end_pulse, irq;
  logic [ROW-1:0] msel;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  capsense_seq_top #(.NUM_STAGES(NS), .NUM_PINS(NP), .TICK_US(32), .CYCLES_PER_TICK(1)) dut (
    .clk(clk), .rst(rst), .pwr_mode_i(pwr_mode), .decim_i(decim), .last_stage_i(last_stage),
    .wake_dly_i(wake), .any_active_i(any_active), .mux_cfg_i(cfg),
    .stage_idx_o(idx), .stage_start_o(st_pulse), .seq_end_o(end_pulse),
    .seq_irq_o(irq), .mux_sel_o(msel)
  );

  // {decim code, last stage, expected start-to-start cycles}
  localparam int VEC [7][3] = '{
    '{2, 0, 24}, '{2, 5, 144}, '{1, 2, 144}, '{0, 1, 192},
    '{3, 11, 288}, '{2, 15, 288}, '{0, 11, 1152}
  };

  function automatic logic [ROW-1:0] exp_row(input int s);
    logic [ROW-1:0] r;
    for (int p = 0; p < NP; p++) r[2*p +: 2] = 2'((s + p) % 4);
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_s0(output int at);
    do @(negedge clk); while (!(st_pulse && idx == 0));
    at = cyc;
  endtask

  task automatic wait_end(output int at);
    do @(negedge clk); while (!end_pulse);
    at = cyc;
  endtask

  // Called at a stage 0 start; follows the sequence to the next stage 0 start.
  task automatic run_seq(output int period, output int cnt, output int maxi, output int merr);
    int t0 = cyc;
    int prev = 0;
    cnt = 1; maxi = 0; merr = (msel != exp_row(0)) ? 1 : 0;
    forever begin
      @(negedge clk);
      if (st_pulse) begin
        if (idx == 0) begin
          period = cyc - t0;
          break;
        end
        cnt++;
        if (int'(idx) != prev + 1) merr++;
        prev = int'(idx);
        if (int'(idx) > maxi) maxi = int'(idx);
        if (msel != exp_row(int'(idx))) merr++;
      end
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int s, s2, e, per, cnt, mx, me, starts, ends;
    for (int st = 0; st < NS; st++) cfg[st*ROW +: ROW] = exp_row(st);

    // R1: reset state
    repeat (4) @(negedge clk);
    chk(idx == 0 && !st_pulse && !end_pulse && !irq, "R1 reset outputs", idx, 0);
    chk(msel == '0, "R1 reset pin codes", msel, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(st_pulse && idx == 0, "R1 first start after release", st_pulse, 1);

    // R2/R3/R4/R8: table walk in full power
    foreach (VEC[i]) begin
      decim = 2'(VEC[i][0]);
      last_stage = SW'(VEC[i][1]);
      wait_s0(s);
      run_seq(per, cnt, mx, me);
      chk(per == VEC[i][2], "R4 R3 sequence period", per, VEC[i][2]);
      chk(cnt == ((VEC[i][1] > 11) ? 12 : VEC[i][1] + 1), "R2 stage count", cnt,
          (VEC[i][1] > 11) ? 12 : VEC[i][1] + 1);
      chk(me == 0, "R8 R2 pin codes and order", me, 0);
    end

    // R9: changes mid-sequence apply only to the next sequence
    decim = 2'b10; last_stage = 4'd5;
    wait_s0(s);
    wait_s0(s);
    repeat (30) @(negedge clk);
    decim = 2'b00; last_stage = 4'd1;
    wait_s0(s2);
    chk(s2 - s == 144, "R9 current sequence keeps old setup", s2 - s, 144);
    run_seq(per, cnt, mx, me);
    chk(per == 192 && cnt == 2, "R9 next sequence uses new setup", per, 192);

    // R10/R4: interrupt timing
    decim = 2'b10; last_stage = 4'd2;
    wait_s0(s);
    do wait_s0(s); while (!end_pulse);
    chk(irq == 1'b1, "R10 irq with end pulse", irq, 1);
    repeat (23) @(negedge clk);
    chk(irq == 1'b1, "R10 irq held through stage 0", irq, 1);
    @(negedge clk);
    chk(irq == 1'b0 && st_pulse && idx == 1, "R10 R3 irq cleared at stage 0 end", irq, 0);

    // R7: shutdown code 01 mid-sequence
    last_stage = 4'd5;
    wait_s0(s);
    wait_s0(s);
    repeat (30) @(negedge clk);
    pwr_mode = 2'b01;
    repeat (10) @(negedge clk);
    chk(idx == 1 && msel == exp_row(1), "R7 stage in progress completes", idx, 1);
    starts = 0; ends = 0;
    repeat (300) begin
      @(negedge clk);
      if (st_pulse) starts++;
      if (end_pulse) ends++;
    end
    chk(starts == 0 && ends == 0, "R7 no pulses in shutdown 01", starts + ends, 0);
    chk(idx == 0 && msel == '0 && !irq, "R7 idle outputs in shutdown", msel, 0);

    // R7/R10: shutdown code 11 at a final stage clears the interrupt
    last_stage = 4'd0;
    pwr_mode = 2'b00;
    wait_s0(s);
    do wait_s0(s); while (!end_pulse);
    pwr_mode = 2'b11;
    repeat (10) @(negedge clk);
    chk(irq == 1'b1, "R10 irq before shutdown", irq, 1);
    starts = 0; ends = 0;
    repeat (200) begin
      @(negedge clk);
      if (st_pulse) starts++;
      if (end_pulse) ends++;
    end
    chk(starts == 0 && ends == 0, "R7 no pulses in shutdown 11", starts + ends, 0);
    chk(irq == 1'b0, "R10 irq cleared by shutdown", irq, 0);

    // R5: low power wake delays
    decim = 2'b10; last_stage = 4'd1; any_active = 1'b0;
    pwr_mode = 2'b00;
    wait_s0(s);
    pwr_mode = 2'b10; wake = 2'b00;
    wait_end(e); wait_s0(s);
    chk(s - e == 6250, "R5 delay code 00", s - e, 6250);
    wake = 2'b01;
    wait_end(e); wait_s0(s);
    chk(s - e == 12500, "R5 delay code 01", s - e, 12500);
    wake = 2'b11;
    wait_end(e); wait_s0(s);
    chk(s - e == 25000, "R5 delay code 11", s - e, 25000);

    // R6: fast cadence while active
    any_active = 1'b1;
    wait_s0(s2);
    chk(s2 - s == 1125, "R6 36 ms cadence", s2 - s, 1125);
    decim = 2'b00; last_stage = 4'd11;
    wait_s0(s);
    chk(s - s2 == 1125, "R6 R9 cadence before long sequence", s - s2, 1125);
    wait_s0(s2);
    chk(s2 - s == 1152, "R6 long sequence back-to-back", s2 - s, 1152);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule